// File: doc/BRIEF.md
# Packed Double-Lane Blend Unit

This block is a vector execution unit that merges two packed operands one 64-bit lane at a time. A 256-bit datapath is split into four lanes. Each lane of the result comes either from the first operand or from the second operand, and a bit of an 8-bit immediate mask makes that choice. Lane values pass through as raw bit patterns. No arithmetic is done on them, so no floating-point flag can be raised.

A two-bit mode input sets the operand width and what happens to the upper half (bits 255:128) of the result.
- In the narrow destination-merged mode, the current destination value stands in for the first operand, and the upper half keeps the destination's prior contents.
- In the narrow three-operand mode, two separate sources are blended in the lower half and the upper half is cleared.
- In the full-width mode, all four lanes are blended.

The issue logic presents the operands, the current destination value and the mode together with a valid strobe. The registered result follows one cycle later.

Top module: `lane_blend_unit`

## Requirements
- R1: In every mode that blends, a lane whose mask bit is 1 takes the second operand `src_b`, and a lane whose mask bit is 0 takes that mode's first operand. Mask bit i (`imm[i]`) controls lane i, which is bits 64*i+63 down to 64*i.
- R2: With `mode` = 2 (full width), all four lanes are blended from `src_a` (bit 0) and `src_b` (bit 1) using `imm[3:0]`.
- R3: With `mode` = 1 (narrow, three-operand), lanes 0 and 1 are blended from `src_a` and `src_b` using `imm[1:0]`, and bits 255:128 of the result are zero.
- R4: With `mode` = 0 (narrow, destination-merged), `dst_old` is the first operand. Lanes 0 and 1 are blended from `dst_old` and `src_b` using `imm[1:0]`, and bits 255:128 of the result equal `dst_old[255:128]`.
- R5: `imm[7:4]` has no effect on the result in any mode, and `imm[3:2]` has no effect in modes 0 and 1.
- R6: Lane values are copied bit-exactly, whatever bit patterns they hold, including NaN, infinity and negative-zero patterns.
- R7: `out_valid` rises exactly one clock after a cycle with `in_valid` high, and the matching result is on `out_data` at that time. A cycle without `in_valid` produces no `out_valid` one clock later.
- R8: A synchronous reset (`rst` high at a clock edge) clears `out_valid`, even when `in_valid` is high in the same cycle.
- R9: With `mode` = 3 (unused encoding), the block still produces a valid result, and that result equals `dst_old` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| mode | input | 2 | 0 narrow destination-merged, 1 narrow three-operand, 2 full width, 3 unused |
| imm | input | 8 | Immediate lane mask; bit i selects for lane i |
| src_a | input | 256 | First operand (used in modes 1 and 2) |
| src_b | input | 256 | Second operand |
| dst_old | input | 256 | Current destination register value |
| out_valid | output | 1 | Result is valid |
| out_data | output | 256 | Blended result |

## Verification
The assertions assume that `mode`, `imm` and the three operands are stable only in the cycle where `in_valid` is sampled. They also assume that a reset is held for at least one edge before the first strobe. The properties compare the registered result against the operands one clock earlier, so they need no stability beyond that cycle. The bench changes its inputs only on falling edges. It raises reset once from time zero and once in the middle of the run, with a strobe applied in the same cycle. It uses every mode encoding, including the unused one. These conditions keep every sampled operand well-defined.

// File: rtl/blend_pkg.sv
package blend_pkg;

    // Encoding of the operation width / upper-half policy.
    typedef enum logic [1:0] {
        BL_KEEP128 = 2'd0,   // narrow, destination is the first operand, upper half kept
        BL_ZERO128 = 2'd1,   // narrow, two sources, upper half cleared
        BL_FULL256 = 2'd2,   // full width, all lanes blended
        BL_RSVD    = 2'd3    // unused encoding: pass destination through
    } blend_mode_e;

    // Per-lane source chosen by the controller.
    typedef enum logic [1:0] {
        LS_FIRST  = 2'd0,    // src_a lane
        LS_SECOND = 2'd1,    // src_b lane
        LS_HOLD   = 2'd2,    // prior destination lane
        LS_CLEAR  = 2'd3     // all zero
    } lane_src_e;

    localparam int unsigned DEF_LANE_W = 64;
    localparam int unsigned DEF_LANES  = 4;
    localparam int unsigned DEF_IMM_W  = 8;

endpackage

// File: rtl/blend_lane_ctrl.sv
module blend_lane_ctrl
    import blend_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES
) (
    input  blend_mode_e      mode,
    input  logic [LANES-1:0] mask,
    output lane_src_e        sel [LANES]
);

    localparam int unsigned HALF = LANES / 2;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam bit UPPER = (i >= HALF);

        always_comb begin
            sel[i] = LS_HOLD;
            unique case (mode)
                BL_KEEP128: begin
                    if (UPPER) begin
                        sel[i] = LS_HOLD;
                    end else begin
                        sel[i] = mask[i] ? LS_SECOND : LS_HOLD;
                    end
                end
                BL_ZERO128: begin
                    if (UPPER) begin
                        sel[i] = LS_CLEAR;
                    end else begin
                        sel[i] = mask[i] ? LS_SECOND : LS_FIRST;
                    end
                end
                BL_FULL256: begin
                    sel[i] = mask[i] ? LS_SECOND : LS_FIRST;
                end
                default: begin
                    sel[i] = LS_HOLD;
                end
            endcase
        end
    end

endmodule

// File: rtl/blend_lane_mux.sv
module blend_lane_mux
    import blend_pkg::*;
#(
    parameter int unsigned LANE_W = DEF_LANE_W
) (
    input  lane_src_e         sel,
    input  logic [LANE_W-1:0] first_in,
    input  logic [LANE_W-1:0] second_in,
    input  logic [LANE_W-1:0] hold_in,
    output logic [LANE_W-1:0] lane_out
);

    always_comb begin
        unique case (sel)
            LS_FIRST:  lane_out = first_in;
            LS_SECOND: lane_out = second_in;
            LS_HOLD:   lane_out = hold_in;
            default:   lane_out = '0;
        endcase
    end

endmodule

// File: rtl/lane_blend_unit.sv
module lane_blend_unit
    import blend_pkg::*;
#(
    parameter int unsigned LANE_W = DEF_LANE_W,
    parameter int unsigned LANES  = DEF_LANES,
    parameter int unsigned IMM_W  = DEF_IMM_W,
    localparam int unsigned DATA_W = LANE_W * LANES,
    localparam int unsigned HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] dst_old,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } blend_state_t;

    blend_state_t      st_d, st_q;
    blend_mode_e       mode_e;
    lane_src_e         lane_sel [LANES];
    logic [DATA_W-1:0] blend_d;

    assign mode_e = blend_mode_e'(mode);

    // Mask bits above the lane count never reach the datapath.
    if (IMM_W > LANES) begin : g_imm_spare
        logic unused_imm_hi;
        assign unused_imm_hi = ^imm[IMM_W-1:LANES];
    end

    blend_lane_ctrl #(
        .LANES (LANES)
    ) u_ctrl (
        .mode (mode_e),
        .mask (imm[LANES-1:0]),
        .sel  (lane_sel)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_mux
        blend_lane_mux #(
            .LANE_W (LANE_W)
        ) u_mux (
            .sel       (lane_sel[i]),
            .first_in  (src_a[i*LANE_W +: LANE_W]),
            .second_in (src_b[i*LANE_W +: LANE_W]),
            .hold_in   (dst_old[i*LANE_W +: LANE_W]),
            .lane_out  (blend_d[i*LANE_W +: LANE_W])
        );
    end

    // Next-state computation.
    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data = blend_d;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    a_r7_valid_follows_strobe : assert property (
        @(posedge clk) disable iff (rst)
        in_valid |=> out_valid
    );

    a_r7_no_spurious_valid : assert property (
        @(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid
    );

    a_r3_upper_cleared : assert property (
        @(posedge clk) disable iff (rst)
        (in_valid && mode == 2'd1) |=> (out_data[DATA_W-1:HALF_W] == '0)
    );

    a_r4_upper_kept : assert property (
        @(posedge clk) disable iff (rst)
        (in_valid && mode == 2'd0)
            |=> (out_data[DATA_W-1:HALF_W] == $past(dst_old[DATA_W-1:HALF_W]))
    );

    a_r9_unused_passes_dst : assert property (
        @(posedge clk) disable iff (rst)
        (in_valid && mode == 2'd3) |=> (out_data == $past(dst_old))
    );

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        a_r2_lane_takes_second : assert property (
            @(posedge clk) disable iff (rst)
            (in_valid && mode == 2'd2 && imm[i])
                |=> (out_data[i*LANE_W +: LANE_W] == $past(src_b[i*LANE_W +: LANE_W]))
        );
        a_r1_lane_takes_first : assert property (
            @(posedge clk) disable iff (rst)
            (in_valid && mode == 2'd2 && !imm[i])
                |=> (out_data[i*LANE_W +: LANE_W] == $past(src_a[i*LANE_W +: LANE_W]))
        );
    end

endmodule

// File: tb/lane_blend_unit_test.sv
module lane_blend_unit_test;

    localparam int unsigned W = 256;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [1:0]    mode;
    logic [7:0]    imm;
    logic [W-1:0]  src_a, src_b, dst_old;
    logic          out_valid;
    logic [W-1:0]  out_data;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] exp_q [$];
    string        req_q [$];

    always #10 clk = ~clk;   // 50 MHz

    lane_blend_unit uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .mode      (mode),
        .imm       (imm),
        .src_a     (src_a),
        .src_b     (src_b),
        .dst_old   (dst_old),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Reference model written from the requirements.
    function automatic logic [W-1:0] model(input logic [1:0] m, input logic [7:0] k,
                                           input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [W-1:0] d);
        logic [W-1:0] r;
        for (int l = 0; l < 4; l++) begin
            logic [63:0] la, lb, ld, lr;
            la = a[l*64 +: 64];
            lb = b[l*64 +: 64];
            ld = d[l*64 +: 64];
            case (m)
                2'd0:    lr = (l < 2) ? (k[l] ? lb : ld) : ld;
                2'd1:    lr = (l < 2) ? (k[l] ? lb : la) : 64'd0;
                2'd2:    lr = k[l] ? lb : la;
                default: lr = ld;
            endcase
            r[l*64 +: 64] = lr;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] m, input logic [7:0] k, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [W-1:0] d, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        mode     = m;
        imm      = k;
        src_a    = a;
        src_b    = b;
        dst_old  = d;
        exp_q.push_back(model(m, k, a, b, d));
        req_q.push_back(req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic logic [W-1:0] pat(input int seed);
        logic [W-1:0] v;
        for (int l = 0; l < 8; l++) begin
            v[l*32 +: 32] = 32'h9E37_79B9 * (seed * 8 + l + 1) ^ 32'h5A5A_0F0F;
        end
        return v;
    endfunction

    // Monitor: pops one expected item per valid result.
    always begin
        @(negedge clk);
        #1;
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected valid", {255'd0, out_valid}, '0);
            end else begin
                logic [W-1:0] e;
                string        r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(out_data === e, r, out_data, e);
            end
        end
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] a, b, d;
        rst      = 1'b1;
        in_valid = 1'b0;
        mode     = 2'd0;
        imm      = 8'd0;
        src_a    = '0;
        src_b    = '0;
        dst_old  = '0;
        repeat (3) @(negedge clk);
        #1;
        check(out_valid === 1'b0, "R8 reset state", {255'd0, out_valid}, '0);
        @(negedge clk);
        rst = 1'b0;

        a = pat(1);
        b = pat(2);
        d = pat(3);

        // R7: output does not appear before the edge following the strobe.
        idle(1);
        send(2'd2, 8'h05, a, b, d, "R7 latency");
        #5;
        check(out_valid === 1'b0, "R7 not early", {255'd0, out_valid}, '0);

        // R2 / R1: every low mask combination in full width mode.
        for (int k = 0; k < 16; k++) begin
            send(2'd2, 8'(k), pat(k + 10), pat(k + 40), pat(k + 70), "R2 full width blend");
        end
        idle(2);
        #1;
        check(out_valid === 1'b0, "R7 idle no valid", {255'd0, out_valid}, '0);

        // R3: narrow three-operand mode.
        for (int k = 0; k < 4; k++) begin
            send(2'd1, 8'(k), pat(k + 100), pat(k + 110), pat(k + 120), "R3 narrow cleared upper");
        end
        // R4: narrow destination-merged mode.
        for (int k = 0; k < 4; k++) begin
            send(2'd0, 8'(k), pat(k + 130), pat(k + 140), pat(k + 150), "R4 narrow kept upper");
        end
        // R1: all-zero and all-one masks.
        send(2'd2, 8'h00, a, b, d, "R1 mask zero takes first");
        send(2'd2, 8'h0F, a, b, d, "R1 mask one takes second");

        // R5: ignored immediate bits.
        send(2'd2, 8'hA6, a, b, d, "R5 high bits ignored full");
        send(2'd1, 8'hFD, a, b, d, "R5 bits 3:2 ignored narrow zero");
        send(2'd0, 8'h5E, a, b, d, "R5 bits 3:2 ignored narrow keep");
        send(2'd1, 8'h0C, a, b, d, "R5 bits 3:2 alone no effect");

        // R6: special bit patterns copied exactly.
        send(2'd2, 8'h0A,
             {64'h7FF8_0000_0000_0001, 64'h8000_0000_0000_0000,
              64'hFFF0_0000_0000_0000, 64'h0000_0000_0000_0001},
             {64'hFFFF_FFFF_FFFF_FFFF, 64'h7FF0_0000_0000_0000,
              64'h7FF4_0000_0000_0000, 64'h8000_0000_0000_0000},
             d, "R6 bit exact copy");

        // R9: unused encoding passes the destination through.
        send(2'd3, 8'hFF, a, b, d, "R9 unused mode");
        send(2'd3, 8'h00, pat(200), pat(201), pat(202), "R9 unused mode zero mask");
        idle(2);

        // R8: reset in the same cycle as a strobe suppresses the result.
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b1;
        mode     = 2'd2;
        imm      = 8'h0F;
        @(negedge clk);
        rst      = 1'b0;
        in_valid = 1'b0;
        #1;
        check(out_valid === 1'b0, "R8 reset beats strobe", {255'd0, out_valid}, '0);

        // Operation resumes after reset.
        send(2'd1, 8'h02, a, b, d, "R8 resume after reset");
        idle(3);

        check(exp_q.size() == 0, "R7 all results delivered", W'(exp_q.size()), '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule